// File: doc/BRIEF.md
# Dual-Master Cartridge Bus Gate

This block arbitrates one external 16-bit cartridge bus between two processors. The primary is a 16-bit CPU whose cycles end with an acknowledge that the gate may withhold. The secondary is a 32-bit CPU with a request/acknowledge bus. An adapter-enable input and a mode input select one of three behaviours.

With the adapter off, the primary drives the cartridge unchanged. In exclusive mode the primary keeps full use of the bus and the secondary is stalled. In shared mode both masters reach the cartridge. The secondary has priority. The lower-byte write strobe is suppressed for the primary. Secondary writes leave the cartridge untouched.

Every granted cycle has the same shape. There is one grant edge and one cycle with the cartridge strobes active. The read data is latched at the end of that cycle, and then there is one cycle of acknowledge. Mode and adapter settings are sampled only between cycles.

Top module: `cart_bus_gate`

## Requirements
- R1: With `adapterEn` low, primary accesses below 0x400000 drive chip-enable, and they drive the upper and lower write strobes exactly as the byte enables `priUds` (even byte) and `priLds` (odd byte) ask. Secondary requests are never acknowledged in this state.
- R2: With `adapterEn` high and `modeRv` high (exclusive), primary strobes behave as in R1, including the lower write. A pending secondary request gets no acknowledge and causes no cartridge activity until shared mode is selected.
- R3: In shared mode (`adapterEn` high, `modeRv` low), `cartLwrN` stays high on every primary write, whether it is an odd-byte write or a word write.
- R4: In shared mode, a primary even-byte write and a primary word write both assert only `cartUwrN`, and the timer-area strobe still operates.
- R5: A secondary write asserts none of `cartLwrN`, `cartUwrN` or `cartTimeN`, and it is still acknowledged.
- R6: After reset all cartridge strobes are high and both acknowledges are low. A granted cycle drives its strobes during the cycle after the grant edge and acknowledges for exactly one cycle after that, with read data captured from the cartridge.
- R7: The secondary cartridge address is its request offset modulo 8 MB, so offset 0xA00000 reaches cartridge location 0x200000.
- R8: In shared mode the primary reaches the cartridge only through the window 0x800000–0x9FFFFF, mapped to cartridge offset (address − 0x800000). A primary access below 0x400000 gets neither a cartridge cycle nor an acknowledge.
- R9: Primary accesses to 0xA13000–0xA130FF assert `cartTimeN` rather than `cartCeN`, in every mode. The secondary cannot reach this area.
- R10: When both masters request in the same idle cycle in shared mode, the secondary cycle runs first. The primary acknowledge follows the secondary one, three cycles later.
- R11: A secondary byte read (`secByte` high) returns the upper cartridge byte for an even offset and the lower byte for an odd offset, in `secRdata[7:0]` with the upper bits zero.
- R12: A change of `modeRv` while a cycle is in progress does not alter that cycle's strobes. It takes effect from the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adapterEn | input | 1 | Adapter enable; low means primary pass-through |
| modeRv | input | 1 | High: exclusive primary mode; low: shared mode |
| priReq | input | 1 | Primary cycle request, held until acknowledged |
| priAddr | input | 24 | Primary byte address |
| priWrite | input | 1 | Primary cycle is a write |
| priUds | input | 1 | Primary upper (even) byte enable |
| priLds | input | 1 | Primary lower (odd) byte enable |
| priWdata | input | 16 | Primary write data |
| priAck | output | 1 | Primary acknowledge, one cycle |
| priRdata | output | 16 | Primary read data, valid with `priAck` |
| secReq | input | 1 | Secondary cartridge request, held until acknowledged |
| secAddr | input | 32 | Secondary cartridge byte offset |
| secWrite | input | 1 | Secondary cycle is a write |
| secByte | input | 1 | Secondary byte-size access |
| secWdata | input | 16 | Secondary write data |
| secAck | output | 1 | Secondary acknowledge, one cycle |
| secRdata | output | 16 | Secondary read data, valid with `secAck` |
| cartAddr | output | 23 | Cartridge byte address |
| cartWdata | output | 16 | Cartridge write data |
| cartRdata | input | 16 | Cartridge read data |
| cartCeN | output | 1 | Cartridge chip enable, active low |
| cartLwrN | output | 1 | Lower-byte write strobe, active low |
| cartUwrN | output | 1 | Upper-byte write strobe, active low |
| cartTimeN | output | 1 | Timer-area strobe, active low |

## Verification
Primary writes are issued as word, odd-byte and even-byte patterns in each of the three mode states. Comparing the strobe pattern on the cartridge side separates pass-through and exclusive behaviour from the shared-mode lower-write suppression, and shows that even-byte and word writes look the same in shared mode. Secondary reads at wrapped, even and odd offsets separate the address folding from the byte-lane choice. A held secondary request across mode changes, and simultaneous requests, show the stall and the priority order. A mode flip placed inside a live cycle shows that settings are sampled only between cycles.

// File: rtl/cart_gate_pkg.sv
package cart_gate_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_DRIVE = 2'd1,
    GS_DONE  = 2'd2
  } gate_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // load request attributes this edge
    logic takeSec;   // capture from the secondary master
    logic useWin;    // primary address comes through the shared window
    logic latchRd;   // sample cartridge read data this edge
    logic ceOn;
    logic lwrOn;
    logic uwrOn;
    logic timeOn;
  } gate_strobe_t;

endpackage

// File: rtl/cart_gate_ctrl.sv
module cart_gate_ctrl
  import cart_gate_pkg::*;
#(
  parameter int              PA_W      = 24,
  parameter logic [PA_W-1:0] ROM_END   = 'h3FFFFF,
  parameter logic [PA_W-1:0] WIN_BASE  = 'h800000,
  parameter logic [PA_W-1:0] WIN_END   = 'h9FFFFF,
  parameter logic [PA_W-1:0] TIME_BASE = 'hA13000,
  parameter logic [PA_W-1:0] TIME_END  = 'hA130FF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            adapterEn,
  input  logic            modeRv,
  input  logic            priReq,
  input  logic [PA_W-1:0] priAddr,
  input  logic            priWrite,
  input  logic            priUds,
  input  logic            priLds,
  input  logic            secReq,
  input  logic            secWrite,
  output gate_strobe_t    strb,
  output logic            priAck,
  output logic            secAck
);

  gate_state_e state;
  logic ownerSec, wrQ, udsQ, ldsQ, timeQ;
  logic adapterQ, modeQ;
  logic idle, drive, adEff, rvEff, shared;
  logic priRom, priWin, priTime, priCart;
  logic grantSec, grantPri;

  assign idle  = (state == GS_IDLE);
  assign drive = (state == GS_DRIVE);

  // settings are only sampled between cycles
  assign adEff  = idle ? adapterEn : adapterQ;
  assign rvEff  = idle ? modeRv    : modeQ;
  assign shared = adEff && !rvEff;

  assign priRom  = (priAddr <= ROM_END);
  assign priWin  = (priAddr >= WIN_BASE) && (priAddr <= WIN_END);
  assign priTime = (priAddr >= TIME_BASE) && (priAddr <= TIME_END);
  assign priCart = shared ? priWin : priRom;

  assign grantSec = idle && secReq && shared;
  assign grantPri = idle && priReq && !grantSec && (priCart || priTime);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= GS_IDLE;
      ownerSec <= 1'b0;
      wrQ      <= 1'b0;
      udsQ     <= 1'b0;
      ldsQ     <= 1'b0;
      timeQ    <= 1'b0;
      adapterQ <= 1'b0;
      modeQ    <= 1'b0;
    end else begin
      if (idle) begin
        adapterQ <= adapterEn;
        modeQ    <= modeRv;
      end
      unique case (state)
        GS_IDLE: begin
          if (grantSec) begin
            state    <= GS_DRIVE;
            ownerSec <= 1'b1;
            wrQ      <= secWrite;
            udsQ     <= 1'b0;
            ldsQ     <= 1'b0;
            timeQ    <= 1'b0;
          end else if (grantPri) begin
            state    <= GS_DRIVE;
            ownerSec <= 1'b0;
            wrQ      <= priWrite;
            udsQ     <= priUds;
            ldsQ     <= priLds;
            timeQ    <= priTime;
          end
        end
        GS_DRIVE: state <= GS_DONE;
        GS_DONE:  state <= GS_IDLE;
        default:  state <= GS_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture = grantSec || grantPri;
    strb.takeSec = grantSec;
    strb.useWin  = shared && priWin;
    strb.latchRd = drive;
    strb.ceOn    = drive && !timeQ;
    strb.timeOn  = drive && timeQ;
    // secondary writes never reach the cartridge strobes
    strb.uwrOn   = drive && wrQ && !ownerSec && udsQ;
    // shared mode drops the lower-byte strobe for the primary
    strb.lwrOn   = drive && wrQ && !ownerSec && ldsQ && !(adapterQ && !modeQ);
  end

  assign priAck = (state == GS_DONE) && !ownerSec;
  assign secAck = (state == GS_DONE) && ownerSec;

  assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state != GS_IDLE) |=> $stable(modeQ));

  assert_sec_only_shared_R2: assert property (@(posedge clk) disable iff (!rstN)
    secAck |-> (adapterQ && !modeQ));

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (priAck || secAck) |=> !(priAck || secAck));

endmodule

// File: rtl/cart_gate_dp.sv
module cart_gate_dp
  import cart_gate_pkg::*;
#(
  parameter int PA_W   = 24,
  parameter int SA_W   = 32,
  parameter int CA_W   = 23,
  parameter int WIN_AW = 21,
  parameter int DW     = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  gate_strobe_t    strb,
  input  logic [PA_W-1:0] priAddr,
  input  logic [DW-1:0]   priWdata,
  input  logic [SA_W-1:0] secAddr,
  input  logic [DW-1:0]   secWdata,
  input  logic            secByte,
  input  logic [DW-1:0]   cartRdata,
  output logic [CA_W-1:0] cartAddr,
  output logic [DW-1:0]   cartWdata,
  output logic            cartCeN,
  output logic            cartLwrN,
  output logic            cartUwrN,
  output logic            cartTimeN,
  output logic [DW-1:0]   priRdata,
  output logic [DW-1:0]   secRdata
);

  localparam int LANE_W = DW / 2;

  logic [CA_W-1:0]   addrQ, priMapped;
  logic [DW-1:0]     wdataQ, rdQ;
  logic              byteQ;
  logic [LANE_W-1:0] laneSel;
  logic              unusedBits;

  // bits above the cartridge span fold away (secondary wraps)
  assign unusedBits = ^{secAddr[SA_W-1:CA_W], priAddr[PA_W-1:CA_W]};

  assign priMapped = strb.useWin ? CA_W'(priAddr[WIN_AW-1:0]) : priAddr[CA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      byteQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strb.capture) begin
        if (strb.takeSec) begin
          addrQ  <= secAddr[CA_W-1:0];
          wdataQ <= secWdata;
          byteQ  <= secByte;
        end else begin
          addrQ  <= priMapped;
          wdataQ <= priWdata;
          byteQ  <= 1'b0;
        end
      end
      if (strb.latchRd) rdQ <= cartRdata;
    end
  end

  // even offset = upper lane
  assign laneSel  = addrQ[0] ? rdQ[LANE_W-1:0] : rdQ[DW-1:LANE_W];
  assign secRdata = byteQ ? DW'(laneSel) : rdQ;
  assign priRdata = rdQ;

  assign cartAddr  = addrQ;
  assign cartWdata = wdataQ;
  assign cartCeN   = !strb.ceOn;
  assign cartLwrN  = !strb.lwrOn;
  assign cartUwrN  = !strb.uwrOn;
  assign cartTimeN = !strb.timeOn;

  assert_time_not_ce_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cartTimeN |-> cartCeN);

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cartCeN |=> $stable(cartAddr));

endmodule

// File: rtl/cart_bus_gate.sv
module cart_bus_gate
  import cart_gate_pkg::*;
#(
  parameter int PA_W   = 24,
  parameter int SA_W   = 32,
  parameter int CA_W   = 23,
  parameter int WIN_AW = 21,
  parameter int DW     = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            adapterEn,
  input  logic            modeRv,
  input  logic            priReq,
  input  logic [PA_W-1:0] priAddr,
  input  logic            priWrite,
  input  logic            priUds,
  input  logic            priLds,
  input  logic [DW-1:0]   priWdata,
  output logic            priAck,
  output logic [DW-1:0]   priRdata,
  input  logic            secReq,
  input  logic [SA_W-1:0] secAddr,
  input  logic            secWrite,
  input  logic            secByte,
  input  logic [DW-1:0]   secWdata,
  output logic            secAck,
  output logic [DW-1:0]   secRdata,
  output logic [CA_W-1:0] cartAddr,
  output logic [DW-1:0]   cartWdata,
  input  logic [DW-1:0]   cartRdata,
  output logic            cartCeN,
  output logic            cartLwrN,
  output logic            cartUwrN,
  output logic            cartTimeN
);

  gate_strobe_t strb;

  cart_gate_ctrl #(.PA_W(PA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .adapterEn(adapterEn), .modeRv(modeRv),
    .priReq(priReq), .priAddr(priAddr), .priWrite(priWrite),
    .priUds(priUds), .priLds(priLds), .secReq(secReq), .secWrite(secWrite),
    .strb(strb), .priAck(priAck), .secAck(secAck)
  );

  cart_gate_dp #(
    .PA_W(PA_W), .SA_W(SA_W), .CA_W(CA_W), .WIN_AW(WIN_AW), .DW(DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .priAddr(priAddr), .priWdata(priWdata),
    .secAddr(secAddr), .secWdata(secWdata), .secByte(secByte), .cartRdata(cartRdata),
    .cartAddr(cartAddr), .cartWdata(cartWdata), .cartCeN(cartCeN),
    .cartLwrN(cartLwrN), .cartUwrN(cartUwrN), .cartTimeN(cartTimeN),
    .priRdata(priRdata), .secRdata(secRdata)
  );

  assert_sec_no_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    secAck |-> $past(cartLwrN && cartUwrN && cartTimeN));

endmodule

// File: tb/test_cart_bus_gate.sv
`timescale 1ns/1ps
module test_cart_bus_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adapterEn = 1'b0, modeRv = 1'b0;
  logic        priReq = 1'b0, priWrite = 1'b0, priUds = 1'b0, priLds = 1'b0;
  logic [23:0] priAddr = '0;
  logic [15:0] priWdata = '0;
  logic        priAck;
  logic [15:0] priRdata;
  logic        secReq = 1'b0, secWrite = 1'b0, secByte = 1'b0;
  logic [31:0] secAddr = '0;
  logic [15:0] secWdata = '0;
  logic        secAck;
  logic [15:0] secRdata;
  logic [22:0] cartAddr;
  logic [15:0] cartWdata, cartRdata;
  logic        cartCeN, cartLwrN, cartUwrN, cartTimeN;

  always #10 clk = ~clk;   // 50 MHz

  cart_bus_gate i_cart_bus_gate (.*);

  function automatic logic [15:0] romWord(input logic [22:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction
  assign cartRdata = romWord(cartAddr);

  typedef struct {
    logic [3:0]  strobesN;   // {ce, lwr, uwr, time}
    logic [22:0] addr;
    string       tag;
  } cyc_t;
  cyc_t expQ[$];

  int  checks = 0, errors = 0, secAckCount = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expectCyc(input logic ce, input logic lwr, input logic uwr,
                           input logic tim, input logic [22:0] a, input string tag);
    cyc_t c;
    c.strobesN = {ce, lwr, uwr, tim};
    c.addr = a;
    c.tag = tag;
    expQ.push_back(c);
  endtask

  // monitor: pops the scoreboard for every active cartridge cycle
  always @(negedge clk) begin
    if (rstN) begin
      cyc_t e;
      logic [3:0] seen;
      if (secAck) secAckCount++;
      seen = {cartCeN, cartLwrN, cartUwrN, cartTimeN};
      if (seen != 4'hF) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected cartridge cycle", 32'(seen), 32'hF);
        end else begin
          e = expQ.pop_front();
          check(seen == e.strobesN, e.tag, "strobes {ce,lwr,uwr,time}",
                32'(seen), 32'(e.strobesN));
          check(cartAddr == e.addr, e.tag, "cartridge address",
                32'(cartAddr), 32'(e.addr));
        end
      end
    end
  end

  task automatic priDo(input logic [23:0] a, input logic wr, input logic uds,
                       input logic lds, input logic [15:0] wd, input bit flip,
                       output int lat, output logic [15:0] rd);
    @(negedge clk);
    priAddr = a; priWrite = wr; priUds = uds; priLds = lds; priWdata = wd;
    priReq = 1'b1;
    if (flip) begin
      @(posedge clk);
      #2 modeRv = 1'b1;
    end
    lat = 0;
    rd = '0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (priAck) begin
        lat = i;
        rd = priRdata;
        break;
      end
    end
    priReq = 1'b0;
  endtask

  task automatic secDo(input logic [31:0] a, input logic wr, input logic bsz,
                       input logic [15:0] wd, output int lat, output logic [15:0] rd);
    @(negedge clk);
    secAddr = a; secWrite = wr; secByte = bsz; secWdata = wd;
    secReq = 1'b1;
    lat = 0;
    rd = '0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (secAck) begin
        lat = i;
        rd = secRdata;
        break;
      end
    end
    secReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin : main
    int          lat, pAt, sAt, baseAcks;
    logic [15:0] rd, w;

    // R6: reset state
    repeat (3) @(negedge clk);
    check({cartCeN, cartLwrN, cartUwrN, cartTimeN} == 4'hF, "R6", "strobes in reset",
          32'({cartCeN, cartLwrN, cartUwrN, cartTimeN}), 32'hF);
    check(!priAck && !secAck, "R6", "acks in reset", 32'({priAck, secAck}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // ---- adapter disabled: pass-through, secondary held pending ----
    secAddr = 32'h0000_0004; secWrite = 1'b0; secByte = 1'b0; secReq = 1'b1;

    expectCyc(0, 0, 0, 1, 23'h000100, "R1");
    priDo(24'h000100, 1, 1, 1, 16'h1234, 0, lat, rd);
    check(lat == 2, "R6", "write ack latency", 32'(lat), 32'd2);

    expectCyc(0, 0, 1, 1, 23'h000203, "R1");
    priDo(24'h000203, 1, 0, 1, 16'h00AA, 0, lat, rd);

    expectCyc(0, 1, 0, 1, 23'h000202, "R1");
    priDo(24'h000202, 1, 1, 0, 16'hAA00, 0, lat, rd);

    expectCyc(0, 1, 1, 1, 23'h3FFFFE, "R1");
    priDo(24'h3FFFFE, 0, 1, 1, 16'h0, 0, lat, rd);
    check(lat == 2, "R6", "read ack latency", 32'(lat), 32'd2);
    check(rd == romWord(23'h3FFFFE), "R1", "read data", 32'(rd), 32'(romWord(23'h3FFFFE)));

    expectCyc(1, 0, 1, 0, 23'h2130F1, "R9");
    priDo(24'hA130F1, 1, 0, 1, 16'h0003, 0, lat, rd);
    check(secAckCount == 0, "R1", "secondary acks with adapter off", 32'(secAckCount), 32'd0);

    // ---- exclusive mode: secondary still pending ----
    @(negedge clk);
    adapterEn = 1'b1; modeRv = 1'b1;
    expectCyc(0, 0, 0, 1, 23'h001000, "R2");
    priDo(24'h001000, 1, 1, 1, 16'h5555, 0, lat, rd);
    repeat (4) @(negedge clk);
    check(secAckCount == 0, "R2", "secondary acks in exclusive mode", 32'(secAckCount), 32'd0);

    // switching to shared releases the pending secondary read
    expectCyc(0, 1, 1, 1, 23'h000004, "R2");
    modeRv = 1'b0;
    lat = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (secAck) begin
        lat = i;
        rd = secRdata;
        break;
      end
    end
    secReq = 1'b0;
    check(lat == 2, "R2", "secondary granted after mode change", 32'(lat), 32'd2);
    check(rd == romWord(23'h000004), "R6", "secondary read data", 32'(rd), 32'(romWord(23'h4)));

    // ---- shared mode ----
    expectCyc(0, 1, 0, 1, 23'h000400, "R4");
    priDo(24'h800400, 1, 1, 1, 16'hCAFE, 0, lat, rd);
    check(cartLwrN, "R3", "lower strobe idle after word write", 32'(cartLwrN), 32'd1);

    expectCyc(0, 1, 1, 1, 23'h000401, "R3");
    priDo(24'h800401, 1, 0, 1, 16'h00FE, 0, lat, rd);
    check(lat == 2, "R3", "odd byte write still acknowledged", 32'(lat), 32'd2);

    expectCyc(0, 1, 0, 1, 23'h000402, "R4");
    priDo(24'h800402, 1, 1, 0, 16'hCA00, 0, lat, rd);

    expectCyc(0, 1, 1, 1, 23'h1FFFFE, "R8");
    priDo(24'h9FFFFE, 0, 1, 1, 16'h0, 0, lat, rd);
    check(rd == romWord(23'h1FFFFE), "R8", "window read data", 32'(rd), 32'(romWord(23'h1FFFFE)));

    priDo(24'h000100, 0, 1, 1, 16'h0, 0, lat, rd);
    check(lat == 0, "R8", "low range ack in shared mode", 32'(lat), 32'd0);

    expectCyc(1, 1, 0, 0, 23'h2130F0, "R4");
    priDo(24'hA130F0, 1, 1, 1, 16'h0102, 0, lat, rd);

    expectCyc(0, 1, 1, 1, 23'h000010, "R5");
    secDo(32'h0000_0010, 1, 0, 16'hDEAD, lat, rd);
    check(lat == 2, "R5", "secondary write acknowledged", 32'(lat), 32'd2);

    expectCyc(0, 1, 1, 1, 23'h200000, "R7");
    secDo(32'h00A0_0000, 0, 0, 16'h0, lat, rd);
    check(rd == romWord(23'h200000), "R7", "wrapped read data", 32'(rd), 32'(romWord(23'h200000)));

    expectCyc(0, 1, 1, 1, 23'h000020, "R11");
    secDo(32'h0000_0020, 0, 1, 16'h0, lat, rd);
    w = romWord(23'h000020);
    check(rd == {8'h00, w[15:8]}, "R11", "even byte lane", 32'(rd), 32'({8'h00, w[15:8]}));

    expectCyc(0, 1, 1, 1, 23'h000021, "R11");
    secDo(32'h0000_0021, 0, 1, 16'h0, lat, rd);
    w = romWord(23'h000021);
    check(rd == {8'h00, w[7:0]}, "R11", "odd byte lane", 32'(rd), 32'({8'h00, w[7:0]}));

    // simultaneous requests: secondary first
    @(negedge clk);
    baseAcks = secAckCount;
    expectCyc(0, 1, 1, 1, 23'h000040, "R10");
    expectCyc(0, 1, 1, 1, 23'h000080, "R10");
    priAddr = 24'h800080; priWrite = 1'b0; priUds = 1'b1; priLds = 1'b1; priReq = 1'b1;
    secAddr = 32'h0000_0040; secWrite = 1'b0; secByte = 1'b0; secReq = 1'b1;
    pAt = 0;
    sAt = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (secAck && sAt == 0) begin
        sAt = i;
        check(secRdata == romWord(23'h40), "R10", "secondary data", 32'(secRdata), 32'(romWord(23'h40)));
        secReq = 1'b0;
      end
      if (priAck && pAt == 0) begin
        pAt = i;
        check(priRdata == romWord(23'h80), "R10", "primary data", 32'(priRdata), 32'(romWord(23'h80)));
        priReq = 1'b0;
      end
      if (pAt != 0 && sAt != 0) break;
    end
    check(sAt == 2, "R10", "secondary ack cycle", 32'(sAt), 32'd2);
    check(pAt == 5, "R10", "primary ack cycle", 32'(pAt), 32'd5);
    check(secAckCount == baseAcks + 1, "R10", "secondary ack count", 32'(secAckCount), 32'(baseAcks + 1));

    // mode flip inside a live cycle does not change its strobes
    expectCyc(0, 1, 0, 1, 23'h000600, "R12");
    priDo(24'h800600, 1, 1, 1, 16'hBEEF, 1, lat, rd);
    check(lat == 2, "R12", "cycle completes after mid-cycle flip", 32'(lat), 32'd2);
    // now exclusive: lower strobe returns on a low-range write
    expectCyc(0, 0, 0, 1, 23'h000600, "R12");
    priDo(24'h000600, 1, 1, 1, 16'hBEEF, 0, lat, rd);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R6", "scoreboard drained", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule